// File: doc/BRIEF.md
# Interrupt Status Collector with DMA Halt and Pointer Aliases

This block gathers single-cycle event pulses from a network controller's MAC and DMA engines into one 32-bit interrupt status word. Each event sets a sticky pending bit. Software clears a pending bit by writing a one to it. A small state machine watches the fatal group of pending bits and holds a halt request to the DMA engines until software has cleared every fatal bit. A registered interrupt line raises when any enabled pending bit is set.

The same status word also carries the live receive read pointer, the live transmit read pointer and the sequence number of the message at the head of the receive queue. These fields are read-only and reflect the inputs combinationally. The receive threshold event is produced inside the block by comparing the receive FIFO entry count with a programmed depth.

The halt state machine has two states. `HS_RUN` (no fatal bit pending) moves to `HS_HALT` on transition T_TRIP when any of bits 3, 4 or 7 is pending. `HS_HALT` moves back to `HS_RUN` on transition T_RELEASE once all three are clear. Otherwise each state holds.

Top module: `int_status_unit`

## Requirements
- R1: While reset is held and after it is released, with no events, status bits 7:0 read 0, `irq` is 0 and `dma_halt` is 0.
- R2: A high event on a clock edge sets its pending bit after that edge: bit 0 TX ring empty, bit 1 TX packet sent, bit 2 link failure, bit 3 DMA memory error, bit 4 TX abort, bit 6 RX underflow, bit 7 RX overflow. The bit stays set once the event drops.
- R3: A write with `wr_en` high clears every pending bit whose `wr_mask` bit is 1. Pending bits whose mask bit is 0 are unchanged.
- R4: If an event and a clearing write hit the same bit on the same edge, the bit stays set.
- R5: Bit 5 (RX threshold) is set on any edge where `rx_fifo_count` differs from `rx_depth`. It follows R3 and R4 like the other bits.
- R6: `rd_data` bits 11:8 equal `rx_rptr`, bits 24:16 equal `tx_rptr` and bits 29:25 equal `rx_seq`, all live. Bits 15:12, 31 and 30 read 0.
- R7: `dma_halt` rises one edge after any of bits 3, 4 or 7 becomes set. It stays high while any of those bits is pending, and falls one edge after the last of them is cleared.
- R8: Bits 0, 1, 2, 5 and 6 never cause `dma_halt`.
- R9: `irq` is registered and follows the enabled pending bits with one edge of delay. Bits 0 and 1 are enabled by `tx_int_en`, bit 5 by `rx_int_en`, and bits 2, 3, 4, 6 and 7 are always enabled.
- R10: A pending bit whose enable is low stays pending. It raises `irq` one edge after its enable goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Status write strobe |
| wr_mask | input | 8 | Write-one-to-clear mask for pending bits 7:0 |
| ev_tx_empty | input | 1 | TX ring empty event |
| ev_tx_sent | input | 1 | TX packet sent with interrupt request |
| ev_link_fail | input | 1 | Link failure event |
| ev_mem_err | input | 1 | DMA memory error event (fatal) |
| ev_tx_abort | input | 1 | TX abort event (fatal) |
| ev_rx_underflow | input | 1 | RX underflow event |
| ev_rx_overflow | input | 1 | RX overflow event (fatal) |
| rx_fifo_count | input | 5 | Current RX FIFO entry count |
| rx_depth | input | 5 | Programmed RX threshold depth |
| rx_rptr | input | 4 | Live RX read pointer |
| tx_rptr | input | 9 | Live TX read pointer |
| rx_seq | input | 5 | Sequence number at head of RX queue |
| tx_int_en | input | 1 | Enable for pending bits 0 and 1 |
| rx_int_en | input | 1 | Enable for pending bit 5 |
| rd_data | output | 32 | Status word: pending bits and live aliases |
| irq | output | 1 | Registered interrupt request |
| dma_halt | output | 1 | Halt request to the DMA engines |

## Verification
A pending bit changes in `rd_data` on the same rising edge that samples its event or clearing write. `irq` and `dma_halt` are each one further register away, so they change one edge later. The alias fields follow their inputs with no edge at all. The driver applies each stimulus just after a falling edge and queues the result due after the next rising edge. The monitor compares at the following falling edge. For the delayed outputs, the driver first advances one cycle and then queues the expectation.

// File: rtl/isu_pkg.sv
package isu_pkg;
    localparam int NUM_SRC = 8;

    localparam int B_TX_EMPTY  = 0;
    localparam int B_TX_SENT   = 1;
    localparam int B_LINK_FAIL = 2;
    localparam int B_MEM_ERR   = 3;
    localparam int B_TX_ABORT  = 4;
    localparam int B_RX_THRESH = 5;
    localparam int B_RX_UNDER  = 6;
    localparam int B_RX_OVER   = 7;

    localparam logic [NUM_SRC-1:0] FATAL_MASK =
        (NUM_SRC'(1) << B_MEM_ERR) | (NUM_SRC'(1) << B_TX_ABORT) | (NUM_SRC'(1) << B_RX_OVER);

    typedef enum logic [0:0] {
        HS_RUN  = 1'b0,
        HS_HALT = 1'b1
    } halt_state_e;
endpackage

// File: rtl/isu_status_bank.sv
module isu_status_bank #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q_o[i] <= 1'b0;
            end else if (set_i[i]) begin
                q_o[i] <= 1'b1;
            end else if (clr_i[i]) begin
                q_o[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/isu_thresh_cmp.sv
module isu_thresh_cmp #(
    parameter int W = 5
) (
    input  logic [W-1:0] count_i,
    input  logic [W-1:0] depth_i,
    output logic         hit_o
);
    always_comb begin
        hit_o = (count_i != depth_i);
    end
endmodule

// File: rtl/isu_halt_fsm.sv
module isu_halt_fsm
    import isu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fatal_any_i,
    output logic halt_o
);
    halt_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HS_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HS_RUN:  if (fatal_any_i)  state_d = HS_HALT;  // T_TRIP
            HS_HALT: if (!fatal_any_i) state_d = HS_RUN;   // T_RELEASE
            default: state_d = HS_RUN;
        endcase
    end

    always_comb begin
        unique case (state_q)
            HS_HALT: halt_o = 1'b1;
            default: halt_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/isu_irq_gen.sv
module isu_irq_gen #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pend_i,
    input  logic [N-1:0] en_i,
    output logic         irq_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
        end else begin
            irq_o <= |(pend_i & en_i);
        end
    end
endmodule

// File: rtl/int_status_unit.sv
module int_status_unit
    import isu_pkg::*;
#(
    parameter int RXP_W   = 4,
    parameter int TXP_W   = 9,
    parameter int SEQ_W   = 5,
    parameter int DEPTH_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [7:0]         wr_mask,
    input  logic               ev_tx_empty,
    input  logic               ev_tx_sent,
    input  logic               ev_link_fail,
    input  logic               ev_mem_err,
    input  logic               ev_tx_abort,
    input  logic               ev_rx_underflow,
    input  logic               ev_rx_overflow,
    input  logic [DEPTH_W-1:0] rx_fifo_count,
    input  logic [DEPTH_W-1:0] rx_depth,
    input  logic [RXP_W-1:0]   rx_rptr,
    input  logic [TXP_W-1:0]   tx_rptr,
    input  logic [SEQ_W-1:0]   rx_seq,
    input  logic               tx_int_en,
    input  logic               rx_int_en,
    output logic [31:0]        rd_data,
    output logic               irq,
    output logic               dma_halt
);
    localparam int RXP_LSB = 8;
    localparam int TXP_LSB = 16;
    localparam int SEQ_LSB = TXP_LSB + TXP_W;

    logic               thresh_hit;
    logic [NUM_SRC-1:0] evt_vec;
    logic [NUM_SRC-1:0] clr_vec;
    logic [NUM_SRC-1:0] en_vec;
    logic [NUM_SRC-1:0] status_q;

    isu_thresh_cmp #(.W(DEPTH_W)) u_thresh (
        .count_i (rx_fifo_count),
        .depth_i (rx_depth),
        .hit_o   (thresh_hit)
    );

    always_comb begin
        evt_vec              = '0;
        evt_vec[B_TX_EMPTY]  = ev_tx_empty;
        evt_vec[B_TX_SENT]   = ev_tx_sent;
        evt_vec[B_LINK_FAIL] = ev_link_fail;
        evt_vec[B_MEM_ERR]   = ev_mem_err;
        evt_vec[B_TX_ABORT]  = ev_tx_abort;
        evt_vec[B_RX_THRESH] = thresh_hit;
        evt_vec[B_RX_UNDER]  = ev_rx_underflow;
        evt_vec[B_RX_OVER]   = ev_rx_overflow;
        clr_vec              = wr_en ? wr_mask : '0;
    end

    always_comb begin
        en_vec              = '1;
        en_vec[B_TX_EMPTY]  = tx_int_en;
        en_vec[B_TX_SENT]   = tx_int_en;
        en_vec[B_RX_THRESH] = rx_int_en;
    end

    isu_status_bank #(.N(NUM_SRC)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (evt_vec),
        .clr_i (clr_vec),
        .q_o   (status_q)
    );

    isu_halt_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .fatal_any_i (|(status_q & FATAL_MASK)),
        .halt_o      (dma_halt)
    );

    isu_irq_gen #(.N(NUM_SRC)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_i (status_q),
        .en_i   (en_vec),
        .irq_o  (irq)
    );

    always_comb begin
        rd_data                       = '0;
        rd_data[NUM_SRC-1:0]          = status_q;
        rd_data[RXP_LSB +: RXP_W]     = rx_rptr;
        rd_data[TXP_LSB +: TXP_W]     = tx_rptr;
        rd_data[SEQ_LSB +: SEQ_W]     = rx_seq;
    end
endmodule

// File: rtl/isu_checker.sv
module isu_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [7:0]  wr_mask,
    input logic        ev_tx_empty,
    input logic        ev_tx_sent,
    input logic        ev_mem_err,
    input logic [4:0]  rx_fifo_count,
    input logic [4:0]  rx_depth,
    input logic        tx_int_en,
    input logic        rx_int_en,
    input logic [31:0] rd_data,
    input logic        irq,
    input logic        dma_halt
);
    logic fatal_pend;
    logic any_enabled;

    always_comb begin
        fatal_pend  = rd_data[3] | rd_data[4] | rd_data[7];
        any_enabled = |(rd_data[7:0] & {2'b11, rx_int_en, 3'b111, tx_int_en, tx_int_en});
    end

    a_r2_mem_err_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ev_mem_err |=> rd_data[3]);

    a_r3_one_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_mask[0] && !ev_tx_empty) |=> !rd_data[0]);

    a_r3_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[1] && !(wr_en && wr_mask[1])) |=> rd_data[1]);

    a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_tx_sent && wr_en && wr_mask[1]) |=> rd_data[1]);

    a_r5_thresh_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_fifo_count != rx_depth) |=> rd_data[5]);

    a_r7_trip: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_pend |=> dma_halt);

    a_r8_no_halt: assert property (@(posedge clk) disable iff (!rst_n)
        !fatal_pend |=> !dma_halt);

    a_r9_irq_on: assert property (@(posedge clk) disable iff (!rst_n)
        any_enabled |=> irq);

    a_r9_irq_off: assert property (@(posedge clk) disable iff (!rst_n)
        !any_enabled |=> !irq);
endmodule

bind int_status_unit isu_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_mask       (wr_mask),
    .ev_tx_empty   (ev_tx_empty),
    .ev_tx_sent    (ev_tx_sent),
    .ev_mem_err    (ev_mem_err),
    .rx_fifo_count (rx_fifo_count),
    .rx_depth      (rx_depth),
    .tx_int_en     (tx_int_en),
    .rx_int_en     (rx_int_en),
    .rd_data       (rd_data),
    .irq           (irq),
    .dma_halt      (dma_halt)
);

// File: tb/int_status_unit_bench.sv
module int_status_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_mask = '0;
    logic        ev_tx_empty = 1'b0, ev_tx_sent = 1'b0, ev_link_fail = 1'b0, ev_mem_err = 1'b0;
    logic        ev_tx_abort = 1'b0, ev_rx_underflow = 1'b0, ev_rx_overflow = 1'b0;
    logic [4:0]  rx_fifo_count = '0, rx_depth = '0;
    logic [3:0]  rx_rptr = 4'h3;
    logic [8:0]  tx_rptr = 9'h05a;
    logic [4:0]  rx_seq = 5'h09;
    logic        tx_int_en = 1'b0, rx_int_en = 1'b0;
    logic [31:0] rd_data;
    logic        irq, dma_halt;

    always #2 clk = ~clk;

    int_status_unit u_int_status_unit (.*);

    typedef struct {
        string       tag;
        bit          c_rd, c_irq, c_halt;
        logic [31:0] rd;
        logic        irq;
        logic        halt;
    } item_t;

    item_t q[$];
    int    n_chk = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;

    function automatic logic [31:0] word(input logic [7:0] st);
        return {2'b00, rx_seq, tx_rptr, 4'h0, rx_rptr, st};
    endfunction

    task automatic push(input string tag, input bit c_rd, input logic [7:0] st,
                        input bit c_irq, input logic e_irq, input bit c_halt, input logic e_halt);
        item_t it;
        it.tag = tag; it.c_rd = c_rd; it.c_irq = c_irq; it.c_halt = c_halt;
        it.rd = word(st); it.irq = e_irq; it.halt = e_halt;
        q.push_back(it);
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    // Monitor: compares queued expectations at each falling edge.
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            if (it.c_rd) begin
                n_chk++;
                if (rd_data !== it.rd) begin
                    n_bad++;
                    $display("FAIL %s rd_data actual=%h expected=%h", it.tag, rd_data, it.rd);
                end
            end
            if (it.c_irq) begin
                n_chk++;
                if (irq !== it.irq) begin
                    n_bad++;
                    $display("FAIL %s irq actual=%b expected=%b", it.tag, irq, it.irq);
                end
            end
            if (it.c_halt) begin
                n_chk++;
                if (dma_halt !== it.halt) begin
                    n_bad++;
                    $display("FAIL %s dma_halt actual=%b expected=%b", it.tag, dma_halt, it.halt);
                end
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        tick();
        push("R1 in reset", 1, 8'h00, 1, 0, 1, 0); tick();
        rst_n = 1'b1;
        push("R1 after reset", 1, 8'h00, 1, 0, 1, 0); tick();

        // R6: live aliases
        rx_rptr = 4'ha; tx_rptr = 9'h1c5; rx_seq = 5'h13;
        push("R6 aliases", 1, 8'h00, 0, 0, 0, 0); tick();
        rx_rptr = 4'hf; tx_rptr = 9'h1ff; rx_seq = 5'h1f;
        push("R6 aliases all ones", 1, 8'h00, 0, 0, 0, 0); tick();

        // R2 / R9: TX empty with TX enable low
        ev_tx_empty = 1'b1;
        push("R2 tx empty set", 1, 8'h01, 0, 0, 0, 0); tick();
        ev_tx_empty = 1'b0;
        push("R2 sticky", 1, 8'h01, 1, 0, 0, 0); tick();
        push("R9 gated off", 0, 8'h00, 1, 0, 1, 0); tick();
        // R10: enable later
        tx_int_en = 1'b1;
        push("R10 late enable", 1, 8'h01, 1, 1, 0, 0); tick();

        // R3: write-one-to-clear
        wr_en = 1'b1; wr_mask = 8'h00;
        push("R3 zero mask", 1, 8'h01, 0, 0, 0, 0); tick();
        wr_mask = 8'hfe;
        push("R3 other bits", 1, 8'h01, 0, 0, 0, 0); tick();
        wr_mask = 8'h01;
        push("R3 clear", 1, 8'h00, 1, 1, 0, 0); tick();
        wr_en = 1'b0; wr_mask = 8'h00;
        push("R9 irq falls", 1, 8'h00, 1, 0, 0, 0); tick();

        // R4: set beats clear
        ev_tx_sent = 1'b1; wr_en = 1'b1; wr_mask = 8'h02;
        push("R4 set wins", 1, 8'h02, 0, 0, 0, 0); tick();
        ev_tx_sent = 1'b0; wr_en = 1'b0; wr_mask = 8'h00;
        push("R4 held", 1, 8'h02, 1, 1, 1, 0); tick();
        wr_en = 1'b1; wr_mask = 8'h02;
        push("R3 clear bit1", 1, 8'h00, 0, 0, 0, 0); tick();
        wr_en = 1'b0; wr_mask = 8'h00;
        push("R9 irq idle", 0, 8'h00, 1, 0, 0, 0); tick();

        // R5: threshold compare
        rx_depth = 5'd5; rx_fifo_count = 5'd3;
        push("R5 mismatch", 1, 8'h20, 0, 0, 0, 0); tick();
        rx_fifo_count = 5'd5; wr_en = 1'b1; wr_mask = 8'h20;
        push("R5 equal clears", 1, 8'h00, 1, 0, 1, 0); tick();
        rx_fifo_count = 5'd2;
        push("R5 mismatch beats clear", 1, 8'h20, 0, 0, 0, 0); tick();
        wr_en = 1'b0; wr_mask = 8'h00; rx_int_en = 1'b1;
        push("R9 rx enable", 1, 8'h20, 1, 1, 1, 0); tick();
        rx_fifo_count = 5'd5; wr_en = 1'b1; wr_mask = 8'h20;
        push("R5 clear", 1, 8'h00, 0, 0, 0, 0); tick();
        wr_en = 1'b0; wr_mask = 8'h00;
        push("R9 rx irq falls", 0, 8'h00, 1, 0, 0, 0); tick();

        // R8: non-fatal errors
        ev_link_fail = 1'b1; ev_rx_underflow = 1'b1;
        push("R2 link and underflow", 1, 8'h44, 0, 0, 1, 0); tick();
        ev_link_fail = 1'b0; ev_rx_underflow = 1'b0;
        push("R8 no halt", 1, 8'h44, 1, 1, 1, 0); tick();
        push("R8 still no halt", 0, 8'h00, 0, 0, 1, 0); tick();
        wr_en = 1'b1; wr_mask = 8'h44;
        push("R3 clear errors", 1, 8'h00, 0, 0, 0, 0); tick();
        wr_en = 1'b0; wr_mask = 8'h00;
        push("R9 quiet", 0, 8'h00, 1, 0, 1, 0); tick();

        // R7: fatal halt
        ev_mem_err = 1'b1;
        push("R2 mem err", 1, 8'h08, 0, 0, 1, 0); tick();
        ev_mem_err = 1'b0;
        push("R7 trip", 1, 8'h08, 1, 1, 1, 1); tick();
        ev_tx_abort = 1'b1; ev_rx_overflow = 1'b1;
        push("R2 abort and overflow", 1, 8'h98, 0, 0, 1, 1); tick();
        ev_tx_abort = 1'b0; ev_rx_overflow = 1'b0;
        wr_en = 1'b1; wr_mask = 8'h08;
        push("R7 partial clear", 1, 8'h90, 0, 0, 1, 1); tick();
        wr_en = 1'b0; wr_mask = 8'h00;
        push("R7 still halted", 0, 8'h00, 0, 0, 1, 1); tick();
        wr_en = 1'b1; wr_mask = 8'h90;
        push("R7 last clear", 1, 8'h00, 0, 0, 1, 1); tick();
        wr_en = 1'b0; wr_mask = 8'h00;
        push("R7 release", 1, 8'h00, 1, 0, 1, 0); tick();

        tick();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule